// File: doc/BRIEF.md
# Buffered SPI Master Controller

This block is an SPI master for one slave. It has a transmit queue and a receive queue between a streaming host interface and the serial pins. The host offers bytes on a valid/ready write channel, and they enter the transmit queue. The host collects returned bytes from the receive queue on a valid/ready read channel. While the transmit queue holds data and the receive queue has room, the engine runs full-duplex 8-bit exchanges. Each exchange sends one byte on `mosi` and, at the same time, captures one independent byte from `miso`. When data keeps flowing, consecutive bytes follow each other with no break in `sclk`.

A transmit entry leaves its queue only at the falling `sclk` edge that ends its exchange. It does not leave when the shifter loads it. If `inhibit` is raised in the middle of an exchange, the serial frame is cut short. The byte stays at the head of the queue and is sent again once `inhibit` drops. When the receive queue fills, the engine waits between bytes, so no received byte is ever lost.

Back-pressure rules. A write moves on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low exactly when the transmit queue holds `DEPTH` entries. A write offered while `tx_ready` is low is dropped and sets `tx_overflow`. A read moves on an edge where `rx_valid` and `rx_ready` are both high. `rx_data` shows the oldest stored byte whenever `rx_valid` is high.

Top module: `spi_fifo_master`

## Requirements
- R1: SPI mode 0, MSB first. `sclk` idles low. `mosi` changes only on a falling `sclk` edge or when `ss_n` changes, and `miso` is sampled on each rising edge. Each exchange sends the queued byte and delivers to the receive queue the 8 bits captured, with the first captured bit as bit 7.
- R2: Each `sclk` period lasts `DIV` clock cycles (`DIV` even, at least 2). `ss_n` falls `DIV/2` cycles before the first rising `sclk` edge. `sclk` only toggles while `ss_n` is low.
- R3: The transmit queue holds `DEPTH` (16) bytes. At `DEPTH` entries `tx_ready` is low, and an offered write is dropped and sets the sticky `tx_overflow` flag, which only reset clears.
- R4: `tx_count` rises by one for each accepted write. It falls by one only at the falling `sclk` edge that completes an exchange.
- R5: `inhibit` high during an exchange ends the frame on the next clock edge, with `ss_n` high and `sclk` low. `tx_count` and the receive queue are left unchanged. The same byte is sent in full after `inhibit` returns low. While `inhibit` is high, no exchange starts.
- R6: If, when a byte completes, another transmit byte is queued and the receive queue will still have room, the next byte follows with no gap in `sclk` and `ss_n` stays low. Otherwise `ss_n` is released at that completing edge.
- R7: No exchange starts while `rx_count` equals `DEPTH`, and a byte is never pushed into a full receive queue. Transfers resume once the host reads.
- R8: `rx_valid` is high exactly when `rx_count` is nonzero. Bytes come out in the order they were received, one per accepted read.
- R9: After reset, `ss_n`=1, `sclk`=0, `mosi`=0, both counts are 0, `tx_ready`=1, `rx_valid`=0 and `tx_overflow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Host offers a byte for transmission |
| tx_ready | output | 1 | Transmit queue can accept a byte |
| tx_data | input | 8 | Byte offered for transmission |
| rx_valid | output | 1 | A received byte is available |
| rx_ready | input | 1 | Host takes the received byte |
| rx_data | output | 8 | Oldest received byte |
| inhibit | input | 1 | Blocks new exchanges and aborts a running one |
| tx_count | output | $clog2(DEPTH)+1 | Transmit queue occupancy |
| rx_count | output | $clog2(DEPTH)+1 | Receive queue occupancy |
| tx_overflow | output | 1 | Sticky: a write was offered while full |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| ss_n | output | 1 | Active-low slave select |

## Verification
Results have fixed delays. An accepted write raises `tx_count` on that edge. `ss_n` falls one edge later, once the engine sees a nonzero count. The first rising `sclk` follows `DIV/2` cycles after that. Completion moves `tx_count`, `rx_count` and (for a final byte) `ss_n` on the same edge, `8*DIV` cycles after `ss_n` fell. An `inhibit` takes effect on the next edge. The bench drives on falling clock edges and samples one falling edge after the edge that should show a result. Serial timing is checked by timestamping the `ss_n` and `sclk` edges against multiples of the clock period.

// File: rtl/sff_pkg.sv
package sff_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW
  } sff_state_e;
endpackage

// File: rtl/sff_fifo.sv
module sff_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [W-1:0]             wdata,
  input  logic                     pop,
  input  logic                     peek_sel,
  output logic [W-1:0]             rdata,
  output logic [$clog2(DEPTH):0]   count,
  output logic                     full,
  output logic                     empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  // peek_sel=1 exposes the entry behind the head (prefetch for the next byte)
  assign rdata   = mem[rd_ptr + AW'(peek_sel)];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sff_baud.sv
module sff_baud #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!en || tick)   cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sff_engine.sv
module sff_engine
  import sff_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV   = 4,
  parameter int CW    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inhibit,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic [CW-1:0]     tx_cnt,
  input  logic [CW-1:0]     rx_cnt,
  input  logic              miso,
  output logic              tx_peek,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              sclk,
  output logic              mosi,
  output logic              ss_n
);
  sff_state_e        state;
  logic [BYTE_W-1:0] sreg;
  logic [2:0]        bitcnt;
  logic              rbit, sclk_q, ss_act, tick, last_bit, start_ok, more;

  sff_baud #(.DIV(DIV)) u_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (state != ST_IDLE),
    .tick (tick)
  );

  assign last_bit = (state == ST_HIGH) && (bitcnt == 3'd7);
  assign tx_peek  = last_bit;
  assign start_ok = !inhibit && (tx_cnt != '0) && (rx_cnt != CW'(DEPTH));
  assign more     = (tx_cnt > CW'(1)) && (rx_cnt < CW'(DEPTH - 1));
  // abort wins over completion: an inhibited final edge retires nothing
  assign tx_pop   = last_bit && tick && !inhibit;
  assign rx_push  = tx_pop;
  assign rx_byte  = {sreg[BYTE_W-2:0], rbit};

  assign sclk = sclk_q;
  assign ss_n = !ss_act;
  assign mosi = ss_act ? sreg[BYTE_W-1] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      sreg   <= '0;
      bitcnt <= '0;
      rbit   <= 1'b0;
      sclk_q <= 1'b0;
      ss_act <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (start_ok) begin
        state  <= ST_LEAD;
        ss_act <= 1'b1;
        sreg   <= tx_byte;
        bitcnt <= '0;
      end
    end else if (inhibit) begin
      state  <= ST_IDLE;
      ss_act <= 1'b0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      case (state)
        ST_HIGH: begin
          sclk_q <= 1'b0;
          if (bitcnt == 3'd7) begin
            if (more) begin
              sreg   <= tx_byte;
              bitcnt <= '0;
              state  <= ST_LOW;
            end else begin
              state  <= ST_IDLE;
              ss_act <= 1'b0;
            end
          end else begin
            sreg   <= rx_byte;
            bitcnt <= bitcnt + 3'd1;
            state  <= ST_LOW;
          end
        end
        default: begin
          sclk_q <= 1'b1;
          rbit   <= miso;
          state  <= ST_HIGH;
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import sff_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tx_valid,
  output logic                   tx_ready,
  input  logic [BYTE_W-1:0]      tx_data,
  output logic                   rx_valid,
  input  logic                   rx_ready,
  output logic [BYTE_W-1:0]      rx_data,
  input  logic                   inhibit,
  output logic [$clog2(DEPTH):0] tx_count,
  output logic [$clog2(DEPTH):0] rx_count,
  output logic                   tx_overflow,
  output logic                   sclk,
  output logic                   mosi,
  input  logic                   miso,
  output logic                   ss_n
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              tx_peek, tx_pop, rx_push;
  logic [BYTE_W-1:0] tx_byte, rx_byte;

  sff_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_valid), .wdata(tx_data),
    .pop(tx_pop), .peek_sel(tx_peek),
    .rdata(tx_byte), .count(tx_count),
    .full(tx_full), .empty(tx_empty)
  );

  sff_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .wdata(rx_byte),
    .pop(rx_ready), .peek_sel(1'b0),
    .rdata(rx_data), .count(rx_count),
    .full(rx_full), .empty(rx_empty)
  );

  sff_engine #(.DEPTH(DEPTH), .DIV(DIV), .CW(CW)) u_eng (
    .clk(clk), .rst_n(rst_n), .inhibit(inhibit),
    .tx_byte(tx_byte), .tx_cnt(tx_count), .rx_cnt(rx_count),
    .miso(miso), .tx_peek(tx_peek), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_byte(rx_byte),
    .sclk(sclk), .mosi(mosi), .ss_n(ss_n)
  );

  assign tx_ready = !tx_full;
  assign rx_valid = !rx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    tx_overflow <= 1'b0;
    else if (tx_valid && tx_full)  tx_overflow <= 1'b1;
  end

  // unused-by-design flags kept observable for the checker via counts
  logic unused_ok;
  assign unused_ok = tx_empty ^ rx_full;
endmodule

// File: rtl/sff_checker.sv
module sff_checker #(
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tx_ready,
  input logic                   rx_valid,
  input logic                   inhibit,
  input logic [$clog2(DEPTH):0] tx_count,
  input logic [$clog2(DEPTH):0] rx_count,
  input logic                   tx_overflow,
  input logic                   sclk,
  input logic                   mosi,
  input logic                   ss_n
);
  assert_mosi_mode0_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ss_n && $past(!ss_n) && !$fell(sclk)) |-> $stable(mosi));

  assert_sclk_framed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> !ss_n);

  assert_select_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ss_n) |-> !sclk);

  assert_full_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready |-> (tx_count == DEPTH));

  assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_overflow |=> tx_overflow);

  assert_retire_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count < $past(tx_count)) |-> $fell(sclk));

  assert_inhibit_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && !ss_n) |=> (ss_n && !sclk));

  assert_rx_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= DEPTH);

  assert_rx_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count > $past(rx_count)) |-> $fell(sclk));

  assert_rx_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_count != 0));
endmodule

bind spi_fifo_master sff_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .inhibit(inhibit), .tx_count(tx_count), .rx_count(rx_count),
  .tx_overflow(tx_overflow), .sclk(sclk), .mosi(mosi), .ss_n(ss_n)
);

// File: tb/tb_spi_fifo_master.sv
`timescale 1ns/1ps
module tb_spi_fifo_master;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 16;
  localparam int DIV    = 4;
  localparam int HALF   = DIV / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_valid = 1'b0, rx_ready = 1'b0, inhibit = 1'b0, miso = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_ready, rx_valid, tx_overflow, sclk, mosi, ss_n;
  logic [7:0] rx_data;
  logic [$clog2(DEPTH):0] tx_count, rx_count;

  spi_fifo_master #(.DEPTH(DEPTH), .DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .inhibit(inhibit), .tx_count(tx_count),
    .rx_count(rx_count), .tx_overflow(tx_overflow), .sclk(sclk),
    .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int nsent = 0, nread = 0, nlog = 0, nrise = 0, nssr = 0, s_idx = 0, s_bit = 0;
  logic [7:0] sent [64];
  logic [7:0] mosi_log [64];
  logic [7:0] miso_log [64];
  longint     rise_t [64];
  longint     t_ssfall = 0;
  logic [7:0] s_out = '0, s_in = '0;

  function automatic logic [7:0] pat(int n);
    return 8'((n * 29 + 90) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // slave model: mode 0, MSB first
  always @(negedge ss_n) begin
    t_ssfall = $time;
    s_bit = 0;
    s_out = pat(s_idx);
    s_idx++;
    miso = s_out[7];
  end
  always @(posedge ss_n) begin
    s_bit = 0;
    nssr++;
  end
  always @(posedge sclk) if (!ss_n) begin
    s_in = {s_in[6:0], mosi};
    s_bit++;
    if (nrise < 64) rise_t[nrise] = $time;
    nrise++;
    if (s_bit == 8) begin
      mosi_log[nlog] = s_in;
      miso_log[nlog] = s_out;
      nlog++;
    end
  end
  always @(negedge sclk) if (!ss_n) begin
    if (s_bit == 8) begin
      s_bit = 0;
      s_out = pat(s_idx);
      s_idx++;
      miso = s_out[7];
    end else begin
      miso = s_out[7 - s_bit];
    end
  end

  task automatic push(input logic [7:0] b);
    logic acc;
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = b;
    acc      = tx_ready;
    @(negedge clk);
    tx_valid = 1'b0;
    if (acc) begin
      sent[nsent] = b;
      nsent++;
    end
  endtask

  task automatic pop_check(input string tag);
    logic [7:0] got;
    for (int i = 0; i < 2000 && !rx_valid; i++) @(negedge clk);
    got = rx_data;
    chk(rx_valid == 1'b1, {tag, " rx_valid"}, rx_valid, 1);
    chk(got == miso_log[nread], {tag, " rx_data"}, got, miso_log[nread]);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    nread++;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (tx_count == 0 && ss_n) break;
    end
  endtask

  task automatic t_reset();
    chk(ss_n == 1'b1, "R9 ss_n", ss_n, 1);
    chk(sclk == 1'b0, "R9 sclk", sclk, 0);
    chk(mosi == 1'b0, "R9 mosi", mosi, 0);
    chk(tx_count == 0, "R9 tx_count", tx_count, 0);
    chk(rx_count == 0, "R9 rx_count", rx_count, 0);
    chk(tx_ready == 1'b1 && rx_valid == 1'b0, "R9 ready/valid", {tx_ready, rx_valid}, 2);
    chk(tx_overflow == 1'b0, "R9 overflow", tx_overflow, 0);
  endtask

  task automatic t_single();
    int n0 = nlog;
    nrise = 0;
    push(8'hC3);
    wait_idle();
    chk(nlog == n0 + 1, "R1 one frame", nlog, n0 + 1);
    chk(mosi_log[n0] == 8'hC3, "R1 mosi byte", mosi_log[n0], 8'hC3);
    chk(nrise == 8, "R1 eight edges", nrise, 8);
    chk(rise_t[0] - t_ssfall == HALF * PERIOD, "R2 select lead", rise_t[0] - t_ssfall, HALF * PERIOD);
    chk(rise_t[1] - rise_t[0] == DIV * PERIOD, "R2 sclk period", rise_t[1] - rise_t[0], DIV * PERIOD);
    chk(ss_n == 1'b1, "R6 release when empty", ss_n, 1);
    pop_check("R1 R8 single");
    chk(rx_count == 0, "R8 drained", rx_count, 0);
  endtask

  task automatic t_back2back();
    inhibit = 1'b1;
    push(8'h11); push(8'h82); push(8'hF0);
    chk(tx_count == 3, "R4 count up", tx_count, 3);
    repeat (20) @(negedge clk);
    chk(ss_n == 1'b1 && tx_count == 3, "R5 no start inhibited", tx_count, 3);
    nrise = 0; nssr = 0;
    inhibit = 1'b0;
    wait_idle();
    chk(nrise == 24, "R6 edges", nrise, 24);
    chk(rise_t[23] - rise_t[0] == 23 * DIV * PERIOD, "R6 no gap", rise_t[23] - rise_t[0], 23 * DIV * PERIOD);
    chk(nssr == 1, "R6 single frame", nssr, 1);
    chk(tx_count == 0, "R4 count down", tx_count, 0);
    for (int i = 0; i < 3; i++) pop_check("R8 order");
  endtask

  task automatic t_abort();
    int n0 = nlog;
    push(8'h5E);
    for (int i = 0; i < 100 && ss_n; i++) @(negedge clk);
    repeat (12) @(negedge clk);
    inhibit = 1'b1;
    @(negedge clk);
    chk(ss_n == 1'b1 && sclk == 1'b0, "R5 abort frame", {ss_n, sclk}, 2);
    chk(tx_count == 1, "R5 byte kept", tx_count, 1);
    repeat (10) @(negedge clk);
    chk(tx_count == 1 && rx_count == 0, "R5 held", tx_count, 1);
    chk(nlog == n0, "R5 no frame done", nlog, n0);
    inhibit = 1'b0;
    wait_idle();
    chk(nlog == n0 + 1 && mosi_log[n0] == 8'h5E, "R5 retry byte", mosi_log[n0], 8'h5E);
    pop_check("R5 retry rx");
  endtask

  task automatic t_full();
    int n0 = nlog;
    inhibit = 1'b1;
    for (int i = 0; i < DEPTH; i++) push(8'(i * 7 + 1));
    chk(tx_count == DEPTH && tx_ready == 1'b0, "R3 full", tx_count, DEPTH);
    push(8'hEE);
    chk(tx_overflow == 1'b1, "R3 overflow flag", tx_overflow, 1);
    chk(tx_count == DEPTH, "R3 drop", tx_count, DEPTH);
    inhibit = 1'b0;
    wait_idle();
    chk(rx_count == DEPTH && nlog == n0 + DEPTH, "R7 rx filled", rx_count, DEPTH);
    inhibit = 1'b1;
    push(8'h3A); push(8'hA3);
    inhibit = 1'b0;
    repeat (200) @(negedge clk);
    chk(ss_n == 1'b1 && tx_count == 2, "R7 stall", tx_count, 2);
    pop_check("R7 free one");
    repeat (80) @(negedge clk);
    chk(tx_count == 1 && rx_count == DEPTH, "R7 one byte then stall", tx_count, 1);
    chk(tx_overflow == 1'b1, "R3 sticky", tx_overflow, 1);
    for (int i = 0; i < DEPTH + 1; i++) pop_check("R7 R8 drain");
    wait_idle();
    chk(rx_count == 0 && nread == nlog, "R7 no loss", nread, nlog);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single();
    t_back2back();
    t_abort();
    t_full();
    chk(nlog == nsent, "R1 frame total", nlog, nsent);
    for (int i = 0; i < nsent; i++)
      chk(mosi_log[i] == sent[i], "R1 R3 mosi sequence", mosi_log[i], sent[i]);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule